// File: doc/BRIEF.md
# Multi-Word Burst Transfer Sequencer

This block moves a run of consecutive 32-bit words between memory and the register file for one instruction. A start pulse supplies the operation kind, a base address, a 6-bit word offset, a word count and the first register index. The block then runs the transfer one word at a time over a request/acknowledge memory port. When the transfer ends, it raises either a done pulse or an error pulse.

There are three kinds of operation. A gather copies memory words into a run of registers. A scatter copies a run of registers out to memory. A fill writes the value of a single register to every word of the range. For gather and scatter, the block checks before any memory access that the register run fits inside the register file. A run that does not fit ends in the error pulse, with no traffic on either port.

The word count comes either from a full register value or from a 5-bit immediate. A select input chooses between the two.

Top module: `lsm_seq`

## Requirements
- R1: The first memory address is `base_addr + 4*ofs_field`. Each following word's address is 4 greater than the previous one.
- R2: With `cnt_sel` = 1 the word count is the zero-extended 5-bit `cnt_imm`; with `cnt_sel` = 0 it is the full `cnt_reg` value.
- R3: Gather (`mode` = 0): word i read from memory is written to register `reg_start + i`. `rf_we` pulses only in the cycle the memory acknowledge completes a read, with `rf_wdata` equal to `mem_rdata`.
- R4: Scatter (`mode` = 1): word i is the value of register `reg_start + i` and is written to memory with `mem_we` = 1.
- R5: Fill (`mode` = 2): every word written to memory is the value of register `reg_start`. Fill applies no register-range check, so a fill may have `reg_start + count` above 32.
- R6: For gather or scatter with `reg_start + count` > 32, or for the reserved `mode` = 3, the block pulses `err` one cycle after `start` is taken, with no memory request and no register write. A sum of exactly 32 is legal.
- R7: A word count of zero ends with `done` one cycle after `start` is taken, with no memory request.
- R8: At most one memory request is outstanding. While `mem_req` is high and `mem_ack` is low, `mem_req`, `mem_addr`, `mem_wdata` and `mem_we` keep their values.
- R9: `done` and `err` are never high together. Each lasts exactly one cycle and is followed by the idle state. `start` has no effect while `busy` is high.
- R10: A synchronous active-high `rst` returns the block to idle, including in the middle of a burst. While idle, `mem_req`, `rf_we`, `done`, `err` and `busy` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| mode | input | 2 | 0 gather, 1 scatter, 2 fill, 3 reserved |
| base_addr | input | 32 | Base byte address |
| ofs_field | input | 6 | Word offset added to the base |
| cnt_sel | input | 1 | 1 selects the immediate count |
| cnt_reg | input | 32 | Word count taken from a register |
| cnt_imm | input | 5 | Immediate word count |
| reg_start | input | 5 | First register index |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | 32 | Memory read data, valid with acknowledge |
| rf_raddr | output | 5 | Register file read index |
| rf_rdata | input | 32 | Register file read data (combinational) |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | 5 | Register file write index |
| rf_wdata | output | 32 | Register file write data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle illegal-operation pulse |

## Verification
The bench targets the register-range boundary from both sides. A gather that ends exactly at register 31 must run, while a scatter one word longer must fail cleanly; an off-by-one check either rejects the legal case or lets a bad run reach memory. A huge register count is used to catch a sum that wraps in a narrow adder and turns an illegal run into a short legal one. An immediate count is paired with a conflicting register count, and a fill that starts near the top of the register file is run, so that a wrong count source or a wrongly applied range check shows up in the memory transactions. Acknowledge latencies of zero to two cycles, a second start during a burst, and a reset in the middle of a burst expose a request that drifts before acknowledge, an operation that restarts, or a port left driving after reset.

// File: rtl/lsm_pkg.sv
package lsm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_REQ,
        ST_WAIT_ACK,
        ST_DONE
    } lsm_state_e;

    typedef enum logic [1:0] {
        XM_GATHER  = 2'd0,
        XM_SCATTER = 2'd1,
        XM_FILL    = 2'd2,
        XM_RSVD    = 2'd3
    } lsm_mode_e;

    function automatic logic mode_uses_run(input lsm_mode_e m);
        return (m == XM_GATHER) || (m == XM_SCATTER);
    endfunction

endpackage

// File: rtl/lsm_range_chk.sv
module lsm_range_chk
    import lsm_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int RIDX_W = 5,
    parameter int NREGS  = 32
) (
    input  lsm_mode_e          mode,
    input  logic [CNT_W-1:0]   count,
    input  logic [RIDX_W-1:0]  ridx,
    output logic               illegal,
    output logic               empty
);

    localparam int SUM_W = CNT_W + 1;

    logic [SUM_W-1:0] span;
    logic             run_over;

    // widened by one bit so a large count cannot wrap into a legal span
    assign span     = {1'b0, count} + SUM_W'(ridx);
    assign run_over = span > SUM_W'(NREGS);
    assign empty    = (count == '0);

    always_comb begin
        case (mode)
            XM_GATHER,
            XM_SCATTER: illegal = run_over;
            XM_FILL:    illegal = 1'b0;
            default:    illegal = 1'b1;
        endcase
    end

endmodule

// File: rtl/lsm_xfer_cnt.sv
module lsm_xfer_cnt #(
    parameter int ADDR_W     = 32,
    parameter int CNT_W      = 32,
    parameter int RIDX_W     = 5,
    parameter int OFS_W      = 6,
    parameter int WORD_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              step,
    input  logic              adv_idx,
    input  logic [ADDR_W-1:0] base,
    input  logic [OFS_W-1:0]  ofs,
    input  logic [CNT_W-1:0]  count,
    input  logic [RIDX_W-1:0] ridx,
    output logic [ADDR_W-1:0] addr,
    output logic [RIDX_W-1:0] idx,
    output logic [CNT_W-1:0]  remain,
    output logic              last
);

    localparam int SCALE_SH = $clog2(WORD_BYTES);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [RIDX_W-1:0] idx;
        logic [CNT_W-1:0]  remain;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d.addr   = base + (ADDR_W'(ofs) << SCALE_SH);
            cnt_d.idx    = ridx;
            cnt_d.remain = count;
        end else if (step) begin
            cnt_d.addr   = cnt_q.addr + ADDR_W'(WORD_BYTES);
            cnt_d.remain = cnt_q.remain - CNT_W'(1);
            if (adv_idx) begin
                cnt_d.idx = cnt_q.idx + RIDX_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign addr   = cnt_q.addr;
    assign idx    = cnt_q.idx;
    assign remain = cnt_q.remain;
    assign last   = (cnt_q.remain == CNT_W'(1));

    AST_STEP_HAS_WORK: assert property (@(posedge clk) disable iff (rst)
        step |-> (remain != '0)); // R7

endmodule

// File: rtl/lsm_seq.sv
module lsm_seq
    import lsm_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int CNT_W      = 32,
    parameter int IMM_CNT_W  = 5,
    parameter int OFS_W      = 6,
    parameter int RIDX_W     = 5,
    parameter int WORD_BYTES = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [1:0]           mode,
    input  logic [ADDR_W-1:0]    base_addr,
    input  logic [OFS_W-1:0]     ofs_field,
    input  logic                 cnt_sel,
    input  logic [CNT_W-1:0]     cnt_reg,
    input  logic [IMM_CNT_W-1:0] cnt_imm,
    input  logic [RIDX_W-1:0]    reg_start,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [DATA_W-1:0]    mem_wdata,
    input  logic                 mem_ack,
    input  logic [DATA_W-1:0]    mem_rdata,
    output logic [RIDX_W-1:0]    rf_raddr,
    input  logic [DATA_W-1:0]    rf_rdata,
    output logic                 rf_we,
    output logic [RIDX_W-1:0]    rf_waddr,
    output logic [DATA_W-1:0]    rf_wdata,
    output logic                 busy,
    output logic                 done,
    output logic                 err
);

    localparam int NREGS = 1 << RIDX_W;

    typedef struct packed {
        lsm_state_e        state;
        lsm_mode_e         mode;
        logic              bad;
        logic [DATA_W-1:0] wdata;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [CNT_W-1:0]  cnt_eff;
    logic [ADDR_W-1:0] cur_addr;
    logic [RIDX_W-1:0] cur_idx;
    logic [CNT_W-1:0]  remain;
    logic              last_word;
    logic              cap;
    logic              step;
    logic              adv_idx;
    logic              illegal;
    logic              empty;

    assign cnt_eff = cnt_sel ? CNT_W'(cnt_imm) : cnt_reg;
    assign adv_idx = (ctl_q.mode != XM_FILL);

    lsm_xfer_cnt #(
        .ADDR_W     (ADDR_W),
        .CNT_W      (CNT_W),
        .RIDX_W     (RIDX_W),
        .OFS_W      (OFS_W),
        .WORD_BYTES (WORD_BYTES)
    ) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .load    (cap),
        .step    (step),
        .adv_idx (adv_idx),
        .base    (base_addr),
        .ofs     (ofs_field),
        .count   (cnt_eff),
        .ridx    (reg_start),
        .addr    (cur_addr),
        .idx     (cur_idx),
        .remain  (remain),
        .last    (last_word)
    );

    lsm_range_chk #(
        .CNT_W  (CNT_W),
        .RIDX_W (RIDX_W),
        .NREGS  (NREGS)
    ) u_chk (
        .mode    (ctl_q.mode),
        .count   (remain),
        .ridx    (cur_idx),
        .illegal (illegal),
        .empty   (empty)
    );

    always_comb begin
        ctl_d = ctl_q;
        cap   = 1'b0;
        step  = 1'b0;
        case (ctl_q.state)
            ST_IDLE: begin
                if (start) begin
                    cap         = 1'b1;
                    ctl_d.mode  = lsm_mode_e'(mode);
                    ctl_d.bad   = 1'b0;
                    ctl_d.state = ST_CHECK;
                end
            end
            ST_CHECK: begin
                if (illegal) begin
                    ctl_d.bad   = 1'b1;
                    ctl_d.state = ST_DONE;
                end else if (empty) begin
                    ctl_d.state = ST_DONE;
                end else begin
                    ctl_d.state = ST_REQ;
                end
            end
            ST_REQ: begin
                // register the outgoing word so it stays fixed until acknowledge
                ctl_d.wdata = rf_rdata;
                ctl_d.state = ST_WAIT_ACK;
            end
            ST_WAIT_ACK: begin
                if (mem_ack) begin
                    step        = 1'b1;
                    ctl_d.state = last_word ? ST_DONE : ST_REQ;
                end
            end
            ST_DONE: begin
                ctl_d.bad   = 1'b0;
                ctl_d.state = ST_IDLE;
            end
            default: begin
                ctl_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '{state: ST_IDLE, mode: XM_GATHER, bad: 1'b0, wdata: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign mem_req   = (ctl_q.state == ST_WAIT_ACK);
    assign mem_we    = mem_req && (ctl_q.mode != XM_GATHER);
    assign mem_addr  = cur_addr;
    assign mem_wdata = ctl_q.wdata;
    assign rf_raddr  = cur_idx;
    assign rf_we     = mem_req && mem_ack && (ctl_q.mode == XM_GATHER);
    assign rf_waddr  = cur_idx;
    assign rf_wdata  = mem_rdata;
    assign busy      = (ctl_q.state != ST_IDLE);
    assign done      = (ctl_q.state == ST_DONE) && !ctl_q.bad;
    assign err       = (ctl_q.state == ST_DONE) && ctl_q.bad;

    AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata) && $stable(mem_we))); // R8

    AST_REJECT_SILENT: assert property (@(posedge clk) disable iff (rst)
        ((ctl_q.state == ST_CHECK) && illegal) |=> (err && !mem_req && !rf_we)); // R6

    AST_EMPTY_FINISH: assert property (@(posedge clk) disable iff (rst)
        ((ctl_q.state == ST_CHECK) && empty && !illegal) |=> (done && !mem_req)); // R7

    AST_WE_ON_READ_ACK: assert property (@(posedge clk) disable iff (rst)
        rf_we |-> (mem_req && mem_ack && !mem_we)); // R3

    AST_END_PULSE: assert property (@(posedge clk) disable iff (rst)
        (done || err) |=> (!done && !err && !busy)); // R9

    AST_END_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(done && err)); // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mem_req && !rf_we)); // R10

endmodule

// File: tb/test_lsm_seq.sv
`timescale 1ns/100ps
module test_lsm_seq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic [31:0] base_addr = '0;
    logic [5:0]  ofs_field = '0;
    logic        cnt_sel = 1'b0;
    logic [31:0] cnt_reg = '0;
    logic [4:0]  cnt_imm = '0;
    logic [4:0]  reg_start = '0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic [4:0]  rf_raddr, rf_waddr;
    logic [31:0] rf_rdata, rf_wdata;
    logic        rf_we, busy, done, err;

    always #2.5 clk = ~clk;

    lsm_seq i_lsm_seq (
        .clk(clk), .rst(rst), .start(start), .mode(mode), .base_addr(base_addr),
        .ofs_field(ofs_field), .cnt_sel(cnt_sel), .cnt_reg(cnt_reg), .cnt_imm(cnt_imm),
        .reg_start(reg_start), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we), .rf_waddr(rf_waddr),
        .rf_wdata(rf_wdata), .busy(busy), .done(done), .err(err)
    );

    logic [31:0] regs [32];
    logic [31:0] mem_m [logic [31:0]];
    assign rf_rdata = regs[rf_raddr];

    int n_chk = 0;
    int n_fail = 0;
    int lat_cfg = 0;
    int wcnt = 0;
    bit pend = 0;
    logic [31:0] p_addr, p_wdata;
    logic        p_we;

    logic [31:0] exp_addr [$];
    bit          exp_we   [$];
    logic [31:0] exp_data [$];
    logic [4:0]  exp_idx  [$];

    function automatic logic [31:0] memval(input logic [31:0] a);
        return mem_m.exists(a) ? mem_m[a] : (a ^ 32'h5A5A_0000);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // memory model and per-cycle comparison against the expected transaction list
    always @(negedge clk) begin
        if (rst) begin
            mem_ack = 1'b0;
            wcnt = 0;
            pend = 0;
        end else begin
            if (!mem_req) begin
                mem_ack = 1'b0;
                wcnt = 0;
            end else if (!mem_ack) begin
                if (wcnt >= lat_cfg) begin
                    mem_ack = 1'b1;
                    mem_rdata = memval(mem_addr);
                end else begin
                    wcnt++;
                end
            end
            #1;
            if (mem_req && mem_ack) begin
                if (exp_addr.size() == 0) begin
                    chk(0, "R6 unexpected memory request", mem_addr, 32'h0);
                end else begin
                    logic [31:0] ea, ed;
                    bit ewe;
                    logic [4:0] ei;
                    ea = exp_addr.pop_front();
                    ewe = exp_we.pop_front();
                    ed = exp_data.pop_front();
                    ei = exp_idx.pop_front();
                    chk(mem_addr == ea, "R1 word address", mem_addr, ea);
                    chk(mem_we == ewe, "R4 transfer direction", 32'(mem_we), 32'(ewe));
                    if (ewe) begin
                        chk(mem_wdata == ed, "R4 R5 write data", mem_wdata, ed);
                        chk(!rf_we, "R3 register write during memory write", 32'(rf_we), 32'h0);
                        mem_m[mem_addr] = mem_wdata;
                    end else begin
                        chk(rf_we, "R3 register write strobe", 32'(rf_we), 32'h1);
                        chk(rf_waddr == ei, "R3 register index", 32'(rf_waddr), 32'(ei));
                        chk(rf_wdata == ed, "R3 register data", rf_wdata, ed);
                        if (rf_we) regs[rf_waddr] = rf_wdata;
                    end
                end
                pend = 0;
            end else begin
                if (rf_we) chk(0, "R3 stray register write", 32'(rf_waddr), 32'h0);
                if (pend && mem_req) begin
                    chk(mem_addr == p_addr && mem_wdata == p_wdata && mem_we == p_we,
                        "R8 request held until acknowledge", mem_addr, p_addr);
                end
                pend = mem_req;
                p_addr = mem_addr;
                p_wdata = mem_wdata;
                p_we = mem_we;
            end
        end
    end

    task automatic issue(input logic [1:0] m, input logic [31:0] b, input logic [5:0] o,
                         input bit sel, input logic [31:0] creg, input logic [4:0] cimm,
                         input logic [4:0] rs, input int lat, output bit bad);
        longint cnt;
        logic [31:0] a;
        cnt = sel ? longint'(cimm) : longint'(creg);
        bad = (m == 2'd3) || ((m != 2'd2) && (longint'(rs) + cnt > 32));
        lat_cfg = lat;
        if (!bad) begin
            for (longint i = 0; i < cnt; i++) begin
                a = b + {24'h0, o, 2'b00} + 32'(i * 4);
                exp_addr.push_back(a);
                exp_we.push_back(m != 2'd0);
                exp_idx.push_back(5'(rs + 5'(i)));
                if (m == 2'd0)      exp_data.push_back(memval(a));
                else if (m == 2'd1) exp_data.push_back(regs[5'(rs + 5'(i))]);
                else                exp_data.push_back(regs[rs]);
            end
        end
        @(negedge clk);
        mode = m; base_addr = b; ofs_field = o; cnt_sel = sel;
        cnt_reg = creg; cnt_imm = cimm; reg_start = rs;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic finish(input bit bad, input bit quick, input bit poke, input string tag);
        int t;
        t = 0;
        while (!(done || err) && t < 5000) begin
            @(negedge clk);
            t++;
            if (poke && t == 3) begin
                mode = 2'd0; base_addr = 32'h0000_8000; cnt_sel = 1'b1; cnt_imm = 5'd2;
                reg_start = 5'd1; start = 1'b1;
            end else begin
                start = 1'b0;
            end
        end
        start = 1'b0;
        chk(err == bad, {tag, " error flag"}, 32'(err), 32'(bad));
        chk(done == !bad, {tag, " done flag"}, 32'(done), 32'(!bad));
        chk(exp_addr.size() == 0, {tag, " all expected words transferred"}, 32'(exp_addr.size()), 32'h0);
        if (quick) chk(t == 1, {tag, " finishes one cycle after start"}, 32'(t), 32'h1);
        @(negedge clk);
        chk(!done && !err && !busy, "R9 single-cycle end pulse then idle",
            {29'h0, done, err, busy}, 32'h0);
    endtask

    initial begin
        bit bad;
        for (int i = 0; i < 32; i++) regs[i] = 32'h1000_0000 + 32'(i) * 32'h0101;
        repeat (3) @(negedge clk);
        chk(!mem_req && !rf_we && !done && !err && !busy, "R10 reset state",
            {27'h0, mem_req, rf_we, done, err, busy}, 32'h0);
        rst = 1'b0;

        // R1 R2 R4: scatter, register count
        issue(2'd1, 32'h0000_1000, 6'd5, 1'b0, 32'd4, 5'd0, 5'd3, 0, bad);
        finish(bad, 0, 0, "R4");
        // R2 R3: gather, immediate count, conflicting register count
        issue(2'd0, 32'h0000_2000, 6'd63, 1'b1, 32'd100, 5'd5, 5'd10, 1, bad);
        finish(bad, 0, 0, "R2");
        // R5: fill running past the top of the register file
        issue(2'd2, 32'h0000_3000, 6'd0, 1'b0, 32'd6, 5'd0, 5'd30, 2, bad);
        finish(bad, 0, 0, "R5");
        // R6 boundary: run ends exactly at register 31
        issue(2'd0, 32'h0000_4000, 6'd1, 1'b1, 32'd0, 5'd4, 5'd28, 0, bad);
        finish(bad, 0, 0, "R6 legal edge");
        // R6: one register too many
        issue(2'd1, 32'h0000_5000, 6'd0, 1'b1, 32'd0, 5'd4, 5'd29, 0, bad);
        finish(bad, 1, 0, "R6 overflow");
        // R6: huge register count must not wrap
        issue(2'd0, 32'h0000_5000, 6'd0, 1'b0, 32'hFFFF_FFFF, 5'd0, 5'd2, 0, bad);
        finish(bad, 1, 0, "R6 wide count");
        // R6: reserved mode
        issue(2'd3, 32'h0000_5000, 6'd0, 1'b1, 32'd0, 5'd1, 5'd0, 0, bad);
        finish(bad, 1, 0, "R6 reserved mode");
        // R7: zero counts
        issue(2'd0, 32'h0000_6000, 6'd2, 1'b1, 32'd7, 5'd0, 5'd31, 0, bad);
        finish(bad, 1, 0, "R7 gather");
        issue(2'd2, 32'h0000_6000, 6'd2, 1'b0, 32'd0, 5'd9, 5'd0, 0, bad);
        finish(bad, 1, 0, "R7 fill");
        // R9: second start during a burst is ignored
        issue(2'd1, 32'h0000_7000, 6'd3, 1'b1, 32'd0, 5'd6, 5'd12, 2, bad);
        finish(bad, 0, 1, "R9");
        // R3: read back the scattered words
        issue(2'd0, 32'h0000_1000, 6'd5, 1'b1, 32'd0, 5'd4, 5'd20, 1, bad);
        finish(bad, 0, 0, "R3");
        chk(regs[20] == 32'h1000_0303 && regs[23] == 32'h1000_0606, "R3 round trip",
            regs[23], 32'h1000_0606);

        // R10: reset in the middle of a burst
        issue(2'd0, 32'h0000_9000, 6'd0, 1'b1, 32'd0, 5'd8, 5'd0, 2, bad);
        repeat (5) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(!mem_req && !rf_we && !done && !err && !busy, "R10 reset during burst",
            {27'h0, mem_req, rf_we, done, err, busy}, 32'h0);
        exp_addr.delete(); exp_we.delete(); exp_data.delete(); exp_idx.delete();
        rst = 1'b0;
        issue(2'd2, 32'h0000_A000, 6'd1, 1'b1, 32'd0, 5'd3, 5'd7, 0, bad);
        finish(bad, 0, 0, "R10 after reset");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule